// File: doc/BRIEF.md
# Store Redo Log

The block is an ordered log of stores kept while a long-latency miss is outstanding. Each store is written at the tail in program order, with its address, data and byte-enable mask. The log does no address matching and never forwards data to loads. Stores that depend on the miss are written with a poison flag. Their data arrives later, when the miss slice re-executes, through a separate completion port.

Once the miss has been serviced, the log replays its contents from the head into the data cache write port. It issues at most one store per cycle and keeps program order. Replay stops at any poisoned entry until that entry's data has been completed.

The block reports the identifier of the oldest entry not yet replayed, so that miss-dependent loads can be held back until every older store has reached the cache. A checkpoint restart cuts the log back by moving the tail to a given identifier.

Top module: `store_redo_log`

## Requirements
- R1: The identifier given to a new store equals the tail position. It has log2(DEPTH) index bits plus one wrap bit on top, and it increases by one per accepted store, wrapping modulo 2*DEPTH. After reset the first identifier is 0.
- R2: When DEPTH entries are held, `alloc_ready` is low and a store offered on `alloc_valid` is not recorded.
- R3: While `miss_returned` is low, `wr_valid` stays low, whatever the log holds.
- R4: While `miss_returned` is high, entries are written out from the head in allocation order, at most one per cycle. Each carries the address, data and mask it was logged with, and the head advances on each cycle in which `wr_valid` and `wr_ready` are both high.
- R5: A store logged with `alloc_poison` high is not written out until `fill_valid` names its identifier. It is then written out with the data from `fill_data` and with the address and mask from allocation.
- R6: `head_id` gives the identifier of the oldest entry not yet written out. `empty` is high exactly when no entry is held.
- R7: A cycle with `restart_valid` high sets the tail to `restart_id`, which discards every entry at or after that identifier. `alloc_ready` is low in that cycle, so the next store accepted receives `restart_id`.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_mask` hold their values into the next cycle.
- R9: After reset the log is empty, `head_id` is 0, `alloc_ready` is 1 and `wr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Store offered for logging |
| alloc_poison | input | 1 | Store depends on the pending miss |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data (ignored when poisoned) |
| alloc_mask | input | DATA_W/8 | Byte enables |
| alloc_ready | output | 1 | Log can accept a store this cycle |
| alloc_id | output | log2(DEPTH)+1 | Identifier of the store being accepted |
| fill_valid | input | 1 | Completion of a poisoned entry's data |
| fill_id | input | log2(DEPTH)+1 | Identifier of the completed entry |
| fill_data | input | DATA_W | Data from slice re-execution |
| miss_returned | input | 1 | Miss serviced; replay allowed |
| restart_valid | input | 1 | Checkpoint restart |
| restart_id | input | log2(DEPTH)+1 | New tail identifier on restart |
| wr_valid | output | 1 | Redo write to cache offered |
| wr_ready | input | 1 | Cache accepts the redo write |
| wr_addr | output | ADDR_W | Redo write address |
| wr_data | output | DATA_W | Redo write data |
| wr_mask | output | DATA_W/8 | Redo write byte enables |
| head_id | output | log2(DEPTH)+1 | Identifier of oldest unreplayed entry |
| empty | output | 1 | No entry held |

## Verification
The assertions take the inputs to be well behaved in three ways. A completion names only an entry that is held and still poisoned. A restart identifier lies between the head and the tail. `miss_returned` does not fall while a redo write is stalled. The stimulus keeps to all three. It completes only the poisoned entry it has just seen blocking the head. It restarts only to an identifier inside the occupied range. It drops `wr_ready` only while `miss_returned` is held high.

// File: rtl/srl_pkg.sv
package srl_pkg;

   function automatic int unsigned idx_bits(int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/srl_ptr.sv
module srl_ptr #(
   parameter int unsigned ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   input  logic            load,
   input  logic [ID_W-1:0] load_val,
   output logic [ID_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (inc)  ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/srl_store.sv
module srl_store #(
   parameter int unsigned DEPTH      = 8,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 32,
   parameter bit          RESET_DATA = 1'b0,
   localparam int unsigned IDX_W     = srl_pkg::idx_bits(DEPTH),
   localparam int unsigned MASK_W    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic              wpoison,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [MASK_W-1:0] wmask,
   input  logic              fe,
   input  logic [IDX_W-1:0]  fidx,
   input  logic [DATA_W-1:0] fdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [MASK_W-1:0] rmask,
   output logic              rpend
);
   logic [DEPTH-1:0]  pend_q;
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [MASK_W-1:0] mask_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (we && widx == IDX_W'(e))      pend_q[e] <= wpoison;
            else if (fe && fidx == IDX_W'(e)) pend_q[e] <= 1'b0;
         end
      end
   end

   generate
      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int e = 0; e < DEPTH; e++) begin
                  addr_q[e] <= '0;
                  data_q[e] <= '0;
                  mask_q[e] <= '0;
               end
            end else begin
               for (int e = 0; e < DEPTH; e++) begin
                  if (we && widx == IDX_W'(e)) begin
                     addr_q[e] <= waddr;
                     data_q[e] <= wdata;
                     mask_q[e] <= wmask;
                  end else if (fe && fidx == IDX_W'(e)) begin
                     data_q[e] <= fdata;
                  end
               end
            end
         end
      end else begin : g_plain_data
         always_ff @(posedge clk) begin
            for (int e = 0; e < DEPTH; e++) begin
               if (we && widx == IDX_W'(e)) begin
                  addr_q[e] <= waddr;
                  data_q[e] <= wdata;
                  mask_q[e] <= wmask;
               end else if (fe && fidx == IDX_W'(e)) begin
                  data_q[e] <= fdata;
               end
            end
         end
      end
   endgenerate

   assign raddr = addr_q[ridx];
   assign rdata = data_q[ridx];
   assign rmask = mask_q[ridx];
   assign rpend = pend_q[ridx];

   AST_FILL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      fe |-> pend_q[fidx]); // R5
endmodule

// File: rtl/srl_drain.sv
module srl_drain (
   input  logic miss_returned,
   input  logic log_empty,
   input  logic head_pend,
   input  logic wr_ready,
   output logic wr_valid,
   output logic head_adv
);
   assign wr_valid = miss_returned && !log_empty && !head_pend;
   assign head_adv = wr_valid && wr_ready;
endmodule

// File: rtl/store_redo_log.sv
module store_redo_log #(
   parameter int unsigned DEPTH      = 8,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 32,
   parameter bit          RESET_DATA = 1'b0,
   localparam int unsigned IDX_W     = srl_pkg::idx_bits(DEPTH),
   localparam int unsigned ID_W      = IDX_W + 1,
   localparam int unsigned MASK_W    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic              alloc_poison,
   input  logic [ADDR_W-1:0] alloc_addr,
   input  logic [DATA_W-1:0] alloc_data,
   input  logic [MASK_W-1:0] alloc_mask,
   output logic              alloc_ready,
   output logic [ID_W-1:0]   alloc_id,
   input  logic              fill_valid,
   input  logic [ID_W-1:0]   fill_id,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              miss_returned,
   input  logic              restart_valid,
   input  logic [ID_W-1:0]   restart_id,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [MASK_W-1:0] wr_mask,
   output logic [ID_W-1:0]   head_id,
   output logic              empty
);
   generate
      if (!srl_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("store_redo_log: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_bad_data
         $error("store_redo_log: DATA_W must be a non-zero multiple of 8");
      end
   endgenerate

   logic [ID_W-1:0] tail_q, head_q, occ;
   logic            full, alloc_fire, head_adv, head_pend;

   assign empty       = (tail_q == head_q);
   assign full        = (tail_q[IDX_W-1:0] == head_q[IDX_W-1:0]) &&
                        (tail_q[ID_W-1] != head_q[ID_W-1]);
   assign alloc_ready = !full && !restart_valid;
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign alloc_id    = tail_q;
   assign head_id     = head_q;
   assign occ         = tail_q - head_q;

   srl_ptr #(.ID_W(ID_W)) i_tail (
      .clk(clk), .rst_n(rst_n), .inc(alloc_fire),
      .load(restart_valid), .load_val(restart_id), .ptr(tail_q)
   );

   srl_ptr #(.ID_W(ID_W)) i_head (
      .clk(clk), .rst_n(rst_n), .inc(head_adv),
      .load(1'b0), .load_val('0), .ptr(head_q)
   );

   srl_store #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_DATA(RESET_DATA)
   ) i_store (
      .clk(clk), .rst_n(rst_n),
      .we(alloc_fire), .widx(tail_q[IDX_W-1:0]), .wpoison(alloc_poison),
      .waddr(alloc_addr), .wdata(alloc_data), .wmask(alloc_mask),
      .fe(fill_valid), .fidx(fill_id[IDX_W-1:0]), .fdata(fill_data),
      .ridx(head_q[IDX_W-1:0]),
      .raddr(wr_addr), .rdata(wr_data), .rmask(wr_mask), .rpend(head_pend)
   );

   srl_drain i_drain (
      .miss_returned(miss_returned), .log_empty(empty), .head_pend(head_pend),
      .wr_ready(wr_ready), .wr_valid(wr_valid), .head_adv(head_adv)
   );

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= ID_W'(DEPTH)); // R2
   AST_DRAIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> miss_returned); // R3
   AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> (head_id == $past(head_id) + 1'b1)); // R4
   AST_RESTART_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      restart_valid |=> (alloc_id == $past(restart_id))); // R7
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                    $stable(wr_data) && $stable(wr_mask))); // R8
endmodule

// File: tb/test_store_redo_log.sv
module test_store_redo_log;
   localparam int unsigned DEPTH  = 4;
   localparam int unsigned ADDR_W = 16;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ID_W   = 3;
   localparam logic [31:0] FILL_D = 32'hCAFE_0001;

   typedef struct packed {
      logic        poison;
      logic [15:0] addr;
      logic [31:0] data;
      logic [3:0]  mask;
   } vec_t;

   localparam vec_t VEC [4] = '{
      '{1'b0, 16'h0100, 32'h1111_0000, 4'hF},
      '{1'b1, 16'h0204, 32'h0000_0000, 4'h3},
      '{1'b0, 16'h0308, 32'h3333_2222, 4'hC},
      '{1'b0, 16'h0100, 32'h4444_5555, 4'h1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              alloc_valid = 1'b0, alloc_poison = 1'b0;
   logic [ADDR_W-1:0] alloc_addr = '0;
   logic [DATA_W-1:0] alloc_data = '0;
   logic [3:0]        alloc_mask = '0;
   logic              alloc_ready;
   logic [ID_W-1:0]   alloc_id;
   logic              fill_valid = 1'b0;
   logic [ID_W-1:0]   fill_id = '0;
   logic [DATA_W-1:0] fill_data = '0;
   logic              miss_returned = 1'b0;
   logic              restart_valid = 1'b0;
   logic [ID_W-1:0]   restart_id = '0;
   logic              wr_valid, wr_ready = 1'b1;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [3:0]        wr_mask;
   logic [ID_W-1:0]   head_id;
   logic              empty;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   store_redo_log #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store_redo_log (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_poison(alloc_poison), .alloc_addr(alloc_addr),
      .alloc_data(alloc_data), .alloc_mask(alloc_mask), .alloc_ready(alloc_ready),
      .alloc_id(alloc_id), .fill_valid(fill_valid), .fill_id(fill_id),
      .fill_data(fill_data), .miss_returned(miss_returned),
      .restart_valid(restart_valid), .restart_id(restart_id),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_mask(wr_mask), .head_id(head_id), .empty(empty)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic next();
      @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9 reset state
      chk("R9 empty", 32'(empty), 1);
      chk("R9 head_id", 32'(head_id), 0);
      chk("R9 alloc_ready", 32'(alloc_ready), 1);
      chk("R9 wr_valid", 32'(wr_valid), 0);

      // R1 log the table with the miss still pending
      for (int i = 0; i < 4; i++) begin
         alloc_valid = 1'b1; alloc_poison = VEC[i].poison; alloc_addr = VEC[i].addr;
         alloc_data = VEC[i].data; alloc_mask = VEC[i].mask;
         #1;
         chk("R1 alloc_id", 32'(alloc_id), 32'(i));
         next();
      end
      alloc_valid = 1'b0;
      #1;
      chk("R2 full alloc_ready", 32'(alloc_ready), 0);
      // R2 offer a store while full; it must not appear in the replay
      alloc_valid = 1'b1; alloc_poison = 1'b0; alloc_addr = 16'hDEAD;
      alloc_data = 32'hBAD0_BAD0; alloc_mask = 4'hF;
      next();
      alloc_valid = 1'b0;
      #1;
      chk("R3 no redo before miss returns", 32'(wr_valid), 0);
      chk("R6 not empty", 32'(empty), 0);

      // R4 R5 replay walk
      miss_returned = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1;
         if (VEC[i].poison) begin
            chk("R5 poisoned head blocks", 32'(wr_valid), 0);
            chk("R6 head_id at blocked entry", 32'(head_id), 32'(i));
            fill_valid = 1'b1; fill_id = ID_W'(i); fill_data = FILL_D;
            next();
            fill_valid = 1'b0;
            #1;
            chk("R5 filled data", wr_data, FILL_D);
         end else begin
            chk("R4 data", wr_data, VEC[i].data);
         end
         chk("R4 valid", 32'(wr_valid), 1);
         chk("R4 addr", 32'(wr_addr), 32'(VEC[i].addr));
         chk("R4 mask", 32'(wr_mask), 32'(VEC[i].mask));
         next();
      end
      chk("R2 rejected store absent, R6 empty", 32'(empty), 1);
      chk("R6 head_id after drain", 32'(head_id), 4);
      chk("R4 idle after drain", 32'(wr_valid), 0);

      // R1 wrap bit and R7 restart
      miss_returned = 1'b0;
      for (int i = 0; i < 3; i++) begin
         alloc_valid = 1'b1; alloc_poison = 1'b0; alloc_addr = 16'h0A00 + 16'(i);
         alloc_data = 32'hA000_0000 + 32'(i); alloc_mask = 4'hF;
         #1;
         chk("R1 wrapped alloc_id", 32'(alloc_id), 32'(4 + i));
         next();
      end
      restart_valid = 1'b1; restart_id = 3'd5;
      #1;
      chk("R7 alloc_ready low on restart", 32'(alloc_ready), 0);
      next();
      restart_valid = 1'b0;
      alloc_addr = 16'h0B05; alloc_data = 32'hB000_0005;
      #1;
      chk("R7 id after restart", 32'(alloc_id), 5);
      next();
      alloc_valid = 1'b0;

      // R8 stall
      miss_returned = 1'b1; wr_ready = 1'b0;
      #1;
      chk("R8 valid under stall", 32'(wr_valid), 1);
      chk("R8 addr first", 32'(wr_addr), 32'h0A00);
      next();
      chk("R8 addr held", 32'(wr_addr), 32'h0A00);
      chk("R8 head held", 32'(head_id), 4);
      wr_ready = 1'b1;
      next();
      chk("R7 younger entry replaced", 32'(wr_addr), 32'h0B05);
      chk("R7 data replaced", wr_data, 32'hB000_0005);
      next();
      chk("R7 discarded entry not replayed", 32'(empty), 1);
      chk("R6 head_id final", 32'(head_id), 6);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule